// File: doc/BRIEF.md
# Bit-addressable internal data memory

This block is the 256-address, byte-wide internal data space of a small 8-bit controller. The lower half is RAM. It holds four banks of eight working registers, a sixteen-byte zone whose bits can also be addressed one at a time, and general storage. The upper half is a window of special-function registers (SFRs). A second, optional 128-byte RAM sits behind the same upper addresses and is reached only through pointers.

An instruction sequencer presents one operation per cycle. The operation carries a kind code, an 8-bit address and write data. The block resolves the operation into a storage location and the read result appears combinationally. Any update takes effect at the next rising clock edge.

Three pieces of state are held inside the block:
- the stack pointer, with its push and pop behaviour;
- the bank-select bits of the status register, which redirect working-register accesses;
- the accumulator parity flag, which the status register always reports.

Top module: `bitmem_top`

## Requirements
- R1: Direct access uses opKind 1 (read) and opKind 2 (write). Addresses 00h–7Fh reach the lower RAM and 80h–FFh reach the SFR window. rdData follows the addressed byte combinationally, and a write is visible from the cycle after its clock edge.
- R2: A bit access uses opKind 7 (read) and opKind 8 (write, value on bitVal). A bit address n below 80h maps to bit n[2:0] of RAM byte 20h + n[6:3]. Byte access and bit access of that byte share one storage.
- R3: A bit address n of 80h or above maps to bit n[2:0] of the SFR at {n[7:3],000}. This works only where that SFR is 80h, 88h, 90h, 98h, A0h, A8h, B0h, B8h, D0h, E0h or F0h. At any other base, a bit write is ignored and a bit read returns 0.
- R4: Working-register access uses opKind 3 (read) and opKind 4 (write). Register n = opAddr[2:0] lives at byte 8×bank + n. bank is bits 4:3 of the status register at D0h and is driven on bankOut.
- R5: Indirect access uses opKind 5 (read) and opKind 6 (write). The address is taken from R0 (opAddr[0]=0) or R1 (opAddr[0]=1) of the active bank. Pointers below 80h reach the lower RAM and pointers of 80h or above reach the upper RAM, never an SFR.
- R6: The stack pointer is the SFR at 81h and is driven on spOut. A push (opKind 9) increments it and writes wrData at the new value, using indirect-space mapping.
- R7: A pop (opKind 10) presents the byte at the current stack pointer on rdData, using indirect-space mapping, and then decrements the pointer. Push and pop both wrap modulo 256.
- R8: Bit 0 of the status register at D0h always reads as the even-parity bit of the accumulator at E0h. Byte writes and bit writes to that bit have no effect, and the other status bits keep their written values.
- R9: The defined SFRs are 80h–83h, 87h–8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, D0h, E0h and F0h. Every other SFR address reads 00h and ignores writes.
- R10: After reset, every RAM and SFR byte is 00h except the stack pointer, which is 07h, so the bank is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Qualifies write, push and pop effects |
| opKind | input | 4 | Operation code (0 idle; others as in R1–R7) |
| opAddr | input | 8 | Byte, bit or register address, or pointer select |
| wrData | input | 8 | Byte to write or push |
| bitVal | input | 1 | Value for a bit write |
| rdData | output | 8 | Byte at the resolved location |
| rdBit | output | 1 | Selected bit for a bit read |
| spOut | output | 8 | Current stack pointer |
| bankOut | output | 2 | Active register bank |

## Verification
The hardest situations to reach are the ones where two views alias the same storage.

- A bank switch must redirect register and pointer accesses mid-stream. The bench rewrites the status register between register sweeps of each bank. It then fetches a pointer held in a non-zero bank.
- Parity must stay immune to writes. The accumulator is swept through all 256 values, and parity-bit writes are attempted in between.
- The stack pointer must cross both the 7Fh/80h boundary and the FFh/00h boundary. Because the pointer is itself writable SFR state, the bench places it directly at those edges before pushing and popping.

// File: rtl/bitmem_pkg.sv
`timescale 1ns/1ps
package bitmem_pkg;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int HALF_DEPTH = 1 << (ADDR_W - 1);
  localparam int IDX_W = ADDR_W - 1;

  localparam logic [IDX_W-1:0] SP_IDX  = 7'h01;
  localparam logic [IDX_W-1:0] PSW_IDX = 7'h50;
  localparam logic [IDX_W-1:0] ACC_IDX = 7'h60;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_DIR_RD = 4'd1,
    OP_DIR_WR = 4'd2,
    OP_REG_RD = 4'd3,
    OP_REG_WR = 4'd4,
    OP_IND_RD = 4'd5,
    OP_IND_WR = 4'd6,
    OP_BIT_RD = 4'd7,
    OP_BIT_WR = 4'd8,
    OP_PUSH   = 4'd9,
    OP_POP    = 4'd10
  } opKind_e;

  typedef enum logic [1:0] {
    SPC_NONE = 2'd0,
    SPC_LOW  = 2'd1,
    SPC_HIGH = 2'd2,
    SPC_SFR  = 2'd3
  } space_e;

  typedef struct packed {
    space_e           space;
    logic [IDX_W-1:0] idx;
    logic [2:0]       bitIdx;
    logic             byteWr;
    logic             bitWr;
    logic             spInc;
    logic             spDec;
  } strobe_t;

  function automatic logic sfrDefined(input logic [IDX_W-1:0] i);
    case (i)
      7'h00, 7'h01, 7'h02, 7'h03, 7'h07, 7'h08, 7'h09, 7'h0A, 7'h0B,
      7'h0C, 7'h0D, 7'h10, 7'h18, 7'h19, 7'h20, 7'h28, 7'h30, 7'h38,
      7'h50, 7'h60, 7'h70: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  function automatic logic sfrBitCapable(input logic [IDX_W-1:0] i);
    return sfrDefined(i) && (i[2:0] == 3'd0);
  endfunction
endpackage

// File: rtl/bitmem_ctrl.sv
`timescale 1ns/1ps
module bitmem_ctrl
  import bitmem_pkg::*;
#(
  parameter bit HAS_UPPER = 1'b1
) (
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [1:0]        bank,
  input  logic [BYTE_W-1:0] ptr0,
  input  logic [BYTE_W-1:0] ptr1,
  input  logic [BYTE_W-1:0] sp,
  output strobe_t           stb
);
  localparam space_e HIGH_SPACE = HAS_UPPER ? SPC_HIGH : SPC_NONE;

  opKind_e           kind;
  logic [BYTE_W-1:0] indPtr;
  logic [BYTE_W-1:0] spNext;

  assign kind   = opKind_e'(opKind);
  assign indPtr = opAddr[0] ? ptr1 : ptr0;
  assign spNext = sp + 8'd1;

  always_comb begin
    stb        = '0;
    stb.space  = SPC_NONE;
    case (kind)
      OP_DIR_RD, OP_DIR_WR: begin
        stb.space  = opAddr[7] ? SPC_SFR : SPC_LOW;
        stb.idx    = opAddr[6:0];
        stb.byteWr = opValid && (kind == OP_DIR_WR);
      end
      OP_REG_RD, OP_REG_WR: begin
        stb.space  = SPC_LOW;
        stb.idx    = {2'b00, bank, opAddr[2:0]};
        stb.byteWr = opValid && (kind == OP_REG_WR);
      end
      OP_IND_RD, OP_IND_WR: begin
        stb.space  = indPtr[7] ? HIGH_SPACE : SPC_LOW;
        stb.idx    = indPtr[6:0];
        stb.byteWr = opValid && (kind == OP_IND_WR);
      end
      OP_BIT_RD, OP_BIT_WR: begin
        if (opAddr[7]) begin
          stb.space = SPC_SFR;
          stb.idx   = {opAddr[6:3], 3'b000};
        end else begin
          stb.space = SPC_LOW;
          stb.idx   = {3'b010, opAddr[6:3]};
        end
        stb.bitIdx = opAddr[2:0];
        stb.bitWr  = opValid && (kind == OP_BIT_WR);
      end
      OP_PUSH: begin
        stb.space  = spNext[7] ? HIGH_SPACE : SPC_LOW;
        stb.idx    = spNext[6:0];
        stb.byteWr = opValid;
        stb.spInc  = opValid;
      end
      OP_POP: begin
        stb.space  = sp[7] ? HIGH_SPACE : SPC_LOW;
        stb.idx    = sp[6:0];
        stb.spDec  = opValid;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitmem_dpath.sv
`timescale 1ns/1ps
module bitmem_dpath
  import bitmem_pkg::*;
#(
  parameter bit                HAS_UPPER = 1'b1,
  parameter logic [BYTE_W-1:0] SP_RESET  = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              bitVal,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdBit,
  output logic [BYTE_W-1:0] sp,
  output logic [1:0]        bank,
  output logic [BYTE_W-1:0] ptr0,
  output logic [BYTE_W-1:0] ptr1
);
  logic [BYTE_W-1:0] lowRam [HALF_DEPTH];
  logic [BYTE_W-1:0] sfrReg [HALF_DEPTH];
  logic [BYTE_W-1:0] highRd;
  logic [BYTE_W-1:0] sfrRd;
  logic [BYTE_W-1:0] curByte;
  logic [BYTE_W-1:0] newByte;
  logic              accParity;
  logic              bitOk;
  logic              wrEn;

  assign accParity = ^sfrReg[ACC_IDX];
  assign sp        = sfrReg[SP_IDX];
  assign bank      = sfrReg[PSW_IDX][4:3];
  assign ptr0      = lowRam[{2'b00, bank, 3'd0}];
  assign ptr1      = lowRam[{2'b00, bank, 3'd1}];

  always_comb begin
    if (!sfrDefined(stb.idx))    sfrRd = '0;
    else if (stb.idx == PSW_IDX) sfrRd = {sfrReg[PSW_IDX][7:1], accParity};
    else                         sfrRd = sfrReg[stb.idx];
  end

  always_comb begin
    case (stb.space)
      SPC_LOW:  curByte = lowRam[stb.idx];
      SPC_HIGH: curByte = highRd;
      SPC_SFR:  curByte = sfrRd;
      default:  curByte = '0;
    endcase
  end

  assign bitOk = (stb.space == SPC_LOW) ||
                 ((stb.space == SPC_SFR) && sfrBitCapable(stb.idx));
  assign rdData = curByte;
  assign rdBit  = bitOk && curByte[stb.bitIdx];

  always_comb begin
    newByte = wrData;
    if (stb.bitWr) begin
      newByte = curByte;
      newByte[stb.bitIdx] = bitVal;
    end
  end
  assign wrEn = stb.byteWr || (stb.bitWr && bitOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF_DEPTH; i++) lowRam[i] <= '0;
    end else if (wrEn && stb.space == SPC_LOW) begin
      lowRam[stb.idx] <= newByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF_DEPTH; i++) sfrReg[i] <= '0;
      sfrReg[SP_IDX] <= SP_RESET;
    end else begin
      if (wrEn && stb.space == SPC_SFR && sfrDefined(stb.idx))
        sfrReg[stb.idx] <= newByte;
      if (stb.spInc)      sfrReg[SP_IDX] <= sp + 8'd1;
      else if (stb.spDec) sfrReg[SP_IDX] <= sp - 8'd1;
    end
  end

  generate
    if (HAS_UPPER) begin : g_upper
      logic [BYTE_W-1:0] highRam [HALF_DEPTH];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < HALF_DEPTH; i++) highRam[i] <= '0;
        end else if (wrEn && stb.space == SPC_HIGH) begin
          highRam[stb.idx] <= newByte;
        end
      end
      assign highRd = highRam[stb.idx];
    end else begin : g_noUpper
      assign highRd = '0;
    end
  endgenerate

  // R6: a push advances the pointer by exactly one
  p_sp_push_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.spInc |=> sp == $past(sp) + 8'd1);

  // R7: a pop retreats the pointer by exactly one
  p_sp_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.spDec |=> sp == $past(sp) - 8'd1);

  // R2: a bit write into RAM lands the requested value
  p_bit_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bitWr && stb.space == SPC_LOW) |=>
      lowRam[$past(stb.idx)][$past(stb.bitIdx)] == $past(bitVal));

  // R3: a bit write into a bit-capable SFR lands the requested value
  p_bit_sfr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bitWr && stb.space == SPC_SFR && sfrBitCapable(stb.idx) && stb.idx != PSW_IDX) |=>
      sfrReg[$past(stb.idx)][$past(stb.bitIdx)] == $past(bitVal));
endmodule

// File: rtl/bitmem_top.sv
`timescale 1ns/1ps
module bitmem_top
  import bitmem_pkg::*;
#(
  parameter bit                HAS_UPPER = 1'b1,
  parameter logic [BYTE_W-1:0] SP_RESET  = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              bitVal,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdBit,
  output logic [BYTE_W-1:0] spOut,
  output logic [1:0]        bankOut
);
  strobe_t           stb;
  logic [BYTE_W-1:0] ptr0;
  logic [BYTE_W-1:0] ptr1;

  bitmem_ctrl #(.HAS_UPPER(HAS_UPPER)) u_ctrl (
    .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .bank(bankOut), .ptr0(ptr0), .ptr1(ptr1), .sp(spOut), .stb(stb)
  );

  bitmem_dpath #(.HAS_UPPER(HAS_UPPER), .SP_RESET(SP_RESET)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .bitVal(bitVal),
    .rdData(rdData), .rdBit(rdBit), .sp(spOut), .bank(bankOut),
    .ptr0(ptr0), .ptr1(ptr1)
  );

  // R5: pointer-based and stack accesses never resolve to the SFR window
  p_ind_no_sfr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == 4'd5 || opKind == 4'd6 || opKind == 4'd9 || opKind == 4'd10) |->
      stb.space != SPC_SFR);
endmodule

// File: tb/bitmem_top_tb.sv
`timescale 1ns/1ps
module bitmem_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opKind = '0;
  logic [7:0] opAddr = '0;
  logic [7:0] wrData = '0;
  logic       bitVal = 1'b0;
  logic [7:0] rdData;
  logic       rdBit;
  logic [7:0] spOut;
  logic [1:0] bankOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] gotData;
  logic       gotBit;

  logic [7:0] lowM  [128];
  logic [7:0] highM [128];
  logic [7:0] sfrM  [128];

  always #10 clk = ~clk;

  bitmem_top u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .wrData(wrData), .bitVal(bitVal), .rdData(rdData), .rdBit(rdBit),
    .spOut(spOut), .bankOut(bankOut)
  );

  function automatic logic defd(input logic [7:0] a);
    logic [6:0] i = a[6:0];
    return (i <= 7'h03) || (i >= 7'h07 && i <= 7'h0D) || i == 7'h10 || i == 7'h18 ||
           i == 7'h19 || i == 7'h20 || i == 7'h28 || i == 7'h30 || i == 7'h38 ||
           i == 7'h50 || i == 7'h60 || i == 7'h70;
  endfunction

  function automatic logic bitCap(input logic [7:0] base);
    return defd(base) && base[2:0] == 3'd0;
  endfunction

  function automatic logic [7:0] expDir(input logic [7:0] a);
    if (!a[7]) return lowM[a[6:0]];
    if (!defd(a)) return 8'h00;
    if (a == 8'hD0) return {sfrM[7'h50][7:1], ^sfrM[7'h60]};
    return sfrM[a[6:0]];
  endfunction

  task automatic mWrDir(input logic [7:0] a, input logic [7:0] v);
    if (!a[7]) lowM[a[6:0]] = v;
    else if (defd(a)) sfrM[a[6:0]] = v;
  endtask

  task automatic doOp(input int k, input logic [7:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    opValid = 1'b1; opKind = k[3:0]; opAddr = a; wrData = d; bitVal = b;
    #4;
    gotData = rdData; gotBit = rdBit;
    @(posedge clk);
    #1;
    opValid = 1'b0; opKind = 4'd0;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic wrDir(input logic [7:0] a, input logic [7:0] v);
    doOp(2, a, v, 1'b0);
    mWrDir(a, v);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin lowM[i] = 0; highM[i] = 0; sfrM[i] = 0; end
    sfrM[1] = 8'h07;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    #5;
    chk("R10", spOut, 8'h07, "sp after reset");
    chk("R10", {6'd0, bankOut}, 8'h00, "bank after reset");
    for (int a = 0; a < 256; a++) begin
      doOp(1, a[7:0], 8'h00, 1'b0);
      chk("R10", gotData, expDir(a[7:0]), $sformatf("reset byte %02h", a));
    end

    // R1 lower RAM byte sweep
    for (int a = 0; a < 128; a++) wrDir(a[7:0], 8'((a * 37 + 11) & 255));
    for (int a = 0; a < 128; a++) begin
      doOp(1, a[7:0], 8'h00, 1'b0);
      chk("R1", gotData, 8'((a * 37 + 11) & 255), $sformatf("ram byte %02h", a));
    end

    // R2 byte writes seen by bit reads, then bit writes seen by byte reads
    for (int n = 0; n < 128; n++) begin
      doOp(7, n[7:0], 8'h00, 1'b0);
      chk("R2", {7'd0, gotBit}, {7'd0, lowM[7'h20 + n / 8][n % 8]}, $sformatf("bit read %02h", n));
    end
    for (int n = 0; n < 128; n++) begin
      logic nv;
      nv = ~lowM[7'h20 + n / 8][n % 8];
      doOp(8, n[7:0], 8'h00, nv);
      lowM[7'h20 + n / 8][n % 8] = nv;
      doOp(1, 8'(8'h20 + n / 8), 8'h00, 1'b0);
      chk("R2", gotData, lowM[7'h20 + n / 8], $sformatf("byte after bit %02h", n));
    end
    doOp(8, 8'h25, 8'h00, 1'b1); lowM[7'h24][5] = 1'b1;
    doOp(1, 8'h24, 8'h00, 1'b0);
    chk("R2", gotData[5], 1'b1, "bit 25h lands in byte 24h bit 5");

    // R4 register banks
    for (int b = 0; b < 4; b++) begin
      wrDir(8'hD0, 8'(b << 3));
      #5;
      chk("R4", {6'd0, bankOut}, 8'(b), "bank select");
      for (int r = 0; r < 8; r++) begin
        doOp(4, r[7:0], 8'((b * 8 + r) ^ 8'h5A), 1'b0);
        lowM[b * 8 + r] = 8'((b * 8 + r) ^ 8'h5A);
      end
      for (int r = 0; r < 8; r++) begin
        doOp(1, 8'(b * 8 + r), 8'h00, 1'b0);
        chk("R4", gotData, 8'((b * 8 + r) ^ 8'h5A), $sformatf("bank %0d reg %0d direct", b, r));
        doOp(3, r[7:0], 8'h00, 1'b0);
        chk("R4", gotData, 8'((b * 8 + r) ^ 8'h5A), $sformatf("bank %0d reg %0d", b, r));
      end
    end
    wrDir(8'hD0, 8'h00);

    // R5 indirect access
    wrDir(8'h00, 8'h45);
    wrDir(8'h01, 8'h90);
    doOp(6, 8'h00, 8'h3C, 1'b0); lowM[7'h45] = 8'h3C;
    doOp(1, 8'h45, 8'h00, 1'b0);
    chk("R5", gotData, 8'h3C, "indirect write via R0");
    doOp(6, 8'h01, 8'hC3, 1'b0); highM[7'h10] = 8'hC3;
    doOp(1, 8'h90, 8'h00, 1'b0);
    chk("R5", gotData, expDir(8'h90), "SFR 90h untouched by indirect");
    doOp(5, 8'h01, 8'h00, 1'b0);
    chk("R5", gotData, 8'hC3, "indirect read upper RAM");
    wrDir(8'h10, 8'h50);
    wrDir(8'h50, 8'h6E);
    wrDir(8'hD0, 8'h10);
    doOp(5, 8'h00, 8'h00, 1'b0);
    chk("R5", gotData, 8'h6E, "pointer from bank 2");
    wrDir(8'hD0, 8'h00);

    // R9 SFR window sweep
    for (int a = 128; a < 256; a++) wrDir(a[7:0], 8'(a ^ 8'h3C));
    for (int a = 128; a < 256; a++) begin
      doOp(1, a[7:0], 8'h00, 1'b0);
      chk("R9", gotData, expDir(a[7:0]), $sformatf("sfr %02h", a));
    end
    wrDir(8'hD0, 8'h00);
    wrDir(8'h81, 8'h07);
    wrDir(8'hE0, 8'h00);

    // R3 SFR bit space
    for (int n = 128; n < 256; n++) begin
      for (int v = 1; v >= 0; v--) begin
        logic [7:0] base;
        base = {n[7:3], 3'b000};
        doOp(8, n[7:0], 8'h00, v[0]);
        if (bitCap(base)) sfrM[base[6:0]][n % 8] = v[0];
        doOp(7, n[7:0], 8'h00, 1'b0);
        chk("R3", {7'd0, gotBit}, {7'd0, bitCap(base) & expDir(base)[n % 8]},
            $sformatf("sfr bit %02h value %0d", n, v));
      end
    end
    wrDir(8'hD0, 8'h00);
    wrDir(8'hE0, 8'h00);

    // R8 parity over every accumulator value
    for (int v = 0; v < 256; v++) begin
      wrDir(8'hE0, v[7:0]);
      doOp(1, 8'hD0, 8'h00, 1'b0);
      chk("R8", gotData, {7'd0, ^v[7:0]}, $sformatf("psw for acc %02h", v));
      if (v % 16 == 5) begin
        doOp(8, 8'hD0, 8'h00, ~(^v[7:0]));
        doOp(7, 8'hD0, 8'h00, 1'b0);
        chk("R8", {7'd0, gotBit}, {7'd0, ^v[7:0]}, "parity bit write ignored");
        doOp(2, 8'hD0, {7'h51, ~(^v[7:0])}, 1'b0);
        sfrM[7'h50] = {7'h51, 1'b0};
        doOp(1, 8'hD0, 8'h00, 1'b0);
        chk("R8", gotData, {7'h51, ^v[7:0]}, "psw byte write keeps parity");
        wrDir(8'hD0, 8'h00);
      end
    end
    wrDir(8'hE0, 8'h00);

    // R6 / R7 stack
    wrDir(8'h81, 8'h2F);
    for (int i = 0; i < 5; i++) begin
      doOp(9, 8'h00, 8'(8'hA0 + i), 1'b0);
      lowM[7'h30 + i] = 8'(8'hA0 + i);
    end
    #5 chk("R6", spOut, 8'h34, "sp after five pushes");
    for (int i = 0; i < 5; i++) begin
      doOp(1, 8'(8'h30 + i), 8'h00, 1'b0);
      chk("R6", gotData, 8'(8'hA0 + i), $sformatf("pushed byte %0d", i));
    end
    for (int i = 4; i >= 0; i--) begin
      doOp(10, 8'h00, 8'h00, 1'b0);
      chk("R7", gotData, 8'(8'hA0 + i), $sformatf("popped byte %0d", i));
    end
    #5 chk("R7", spOut, 8'h2F, "sp after five pops");
    wrDir(8'h81, 8'hFF);
    doOp(9, 8'h00, 8'h77, 1'b0); lowM[0] = 8'h77;
    #5 chk("R7", spOut, 8'h00, "push wraps to 00h");
    doOp(1, 8'h00, 8'h00, 1'b0);
    chk("R6", gotData, 8'h77, "push at wrap writes byte 00h");
    doOp(10, 8'h00, 8'h00, 1'b0);
    chk("R7", gotData, 8'h77, "pop at 00h");
    #5 chk("R7", spOut, 8'hFF, "pop wraps to FFh");
    wrDir(8'h81, 8'h7F);
    doOp(9, 8'h00, 8'h99, 1'b0); highM[0] = 8'h99;
    #5 chk("R6", spOut, 8'h80, "push crosses into upper RAM");
    doOp(1, 8'h80, 8'h00, 1'b0);
    chk("R6", gotData, expDir(8'h80), "SFR 80h untouched by push");
    doOp(10, 8'h00, 8'h00, 1'b0);
    chk("R7", gotData, 8'h99, "pop from upper RAM");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule